// File: doc/BRIEF.md
# Capability Check and Guarded Update Unit

This unit enforces memory protection based on tagged fat-pointer capabilities. A capability describes a region of the address space by a base, a length and a current offset. It also carries a permission word, a seal flag with an object type, and a validity tag that is kept apart from the data fields. Each request holds one capability and asks the unit for one of two services. The first service checks a memory access of a given kind (load, store or instruction fetch) and size at a displacement from the capability's current position. The second service applies a guarded manipulation to the capability.

For an access, the unit forms the virtual address before any address translation takes place. It then reports either that the access is allowed or that it faults, together with a cause code. For a manipulation, the unit returns the updated capability, or a fault with the capability unchanged. The supported manipulations are narrowing the bounds, masking the permissions, moving the offset, sealing and unsealing. Authority can never grow through this path. Every result is registered, and requests and results pass through a valid/ready handshake.

Top module: `cap_guard`

## Requirements
- R1: For an access request (req_is_mod=0), rsp_vaddr equals base + offset + req_acc_disp modulo 2^64. The returned capability fields echo the request's capability.
- R2: A request whose capability tag is 0 faults with cause 1 (tag violation). This applies to every access and every manipulation, unseal included.
- R3: A tagged capability with the seal flag set faults with cause 2 (seal violation) on any access and on every manipulation other than unseal. The capability is returned unchanged.
- R4: Permission bit 0 grants load (kind 0), bit 1 grants store (kind 1) and bit 2 grants fetch (kind 2). A missing bit gives cause 3. Access kind 3 is reserved and gives cause 6.
- R5: An access of N = req_acc_size bytes passes the bounds check only if vaddr >= base and vaddr + N <= base + length. Both comparisons are made at 65 bits, so an address that wraps around is refused. A failure gives cause 4.
- R6: When several faults apply, the order is tag (1), then seal (2), then reserved kind or permission (6/3), then bounds (4). rsp_fault is 1 exactly when rsp_cause is nonzero, and cause 0 means allowed.
- R7: Operation 0 (set bounds) takes new base = req_mod_arg and new length = req_mod_arg2. When [arg, arg+arg2) lies inside [base, base+length) at 65 bits, the result has those bounds and offset 0. Otherwise it faults with cause 4 and returns the capability unchanged.
- R8: Operation 1 sets permissions to the current permissions AND req_mod_arg[30:0]. It never adds a permission bit.
- R9: Operation 2 adds req_mod_arg to the offset. It succeeds on any tagged unsealed capability, even when the new offset lies out of bounds.
- R10: Operation 3 sets the seal flag and object type = req_mod_arg[23:0].
- R11: Operation 4 (unseal) has three outcomes. If the capability is unsealed, it gives cause 2. If the object type differs from req_mod_arg[23:0], it gives cause 5. On a match, it clears the seal flag and the object type. Operations 5 to 7 give cause 6.
- R12: A result appears on the response outputs in the cycle after its request is accepted, and req_ready = !rsp_valid || rsp_ready. While rsp_valid=1 and rsp_ready=0, every response output stays unchanged.
- R13: During and right after synchronous reset, rsp_valid is 0 and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_is_mod | input | 1 | 1 = manipulation, 0 = access check |
| req_cap_tag | input | 1 | Validity tag of the capability |
| req_cap_base | input | 64 | Region base |
| req_cap_len | input | 64 | Region length |
| req_cap_off | input | 64 | Current offset |
| req_cap_perm | input | 31 | Permission word |
| req_cap_sealed | input | 1 | Seal flag |
| req_cap_otype | input | 24 | Object type |
| req_acc_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 reserved |
| req_acc_size | input | 4 | Access size in bytes |
| req_acc_disp | input | 64 | Displacement added to base + offset |
| req_mod_op | input | 3 | Manipulation code (0..4 defined) |
| req_mod_arg | input | 64 | Base, mask, increment or object type operand |
| req_mod_arg2 | input | 64 | New length for set bounds |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_fault | output | 1 | Request faulted |
| rsp_cause | output | 3 | Fault cause, 0 = none |
| rsp_vaddr | output | 64 | Virtual address of an access (0 for manipulations) |
| rsp_cap_tag | output | 1 | Result capability tag |
| rsp_cap_base | output | 64 | Result base |
| rsp_cap_len | output | 64 | Result length |
| rsp_cap_off | output | 64 | Result offset |
| rsp_cap_perm | output | 31 | Result permissions |
| rsp_cap_sealed | output | 1 | Result seal flag |
| rsp_cap_otype | output | 24 | Result object type |

## Verification
The bench aims at the edges of the bounds check. It tries an access that ends exactly at the top of the region, one that ends a byte past it, and a region that ends at 2^64 where a 64-bit compare would wrap and admit a stray access. It stacks several faults on one request to expose a wrong priority, which would show up as a bounds or permission cause reported ahead of a tag or seal cause. It sends set-bounds requests that grow the region, which must leave the capability untouched. It sends unseal requests with a wrong object type or on an unsealed capability, which a careless design would let through. It holds rsp_ready low across queued requests so that a design that drops or overwrites a stalled result gives a mismatch in order or value.

// File: rtl/cap_guard_pkg.sv
package cap_guard_pkg;
    parameter int unsigned AW = 64;   // address/bounds width
    parameter int unsigned PW = 31;   // permission word width
    parameter int unsigned OW = 24;   // object type width
    parameter int unsigned SW = 4;    // access size width
    localparam int unsigned XW = AW + 1;

    localparam int unsigned PB_LOAD  = 0;
    localparam int unsigned PB_STORE = 1;
    localparam int unsigned PB_EXEC  = 2;

    typedef struct packed {
        logic          tag;
        logic [AW-1:0] base;
        logic [AW-1:0] len;
        logic [AW-1:0] off;
        logic [PW-1:0] perm;
        logic          sealed;
        logic [OW-1:0] otype;
    } cap_t;

    typedef enum logic [2:0] {
        CZ_NONE    = 3'd0,
        CZ_TAG     = 3'd1,
        CZ_SEAL    = 3'd2,
        CZ_PERM    = 3'd3,
        CZ_BOUNDS  = 3'd4,
        CZ_OTYPE   = 3'd5,
        CZ_ILLEGAL = 3'd6
    } cause_e;

    typedef enum logic [1:0] {
        AK_LOAD  = 2'd0,
        AK_STORE = 2'd1,
        AK_FETCH = 2'd2,
        AK_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        MO_SETB   = 3'd0,
        MO_ANDP   = 3'd1,
        MO_INCO   = 3'd2,
        MO_SEAL   = 3'd3,
        MO_UNSEAL = 3'd4
    } mod_op_e;

    // [lo, lo+n) inside [base, base+len), evaluated one bit wider so no sum wraps
    function automatic logic region_inside(input logic [AW-1:0] base,
                                           input logic [AW-1:0] len,
                                           input logic [AW-1:0] lo,
                                           input logic [AW-1:0] n);
        logic [XW-1:0] lo_x, hi_x, top_x;
        lo_x  = {1'b0, lo};
        hi_x  = {1'b0, lo} + {1'b0, n};
        top_x = {1'b0, base} + {1'b0, len};
        return (lo_x >= {1'b0, base}) && (hi_x <= top_x);
    endfunction
endpackage

// File: rtl/cap_access_chk.sv
module cap_access_chk
    import cap_guard_pkg::*;
(
    input  cap_t           cap,
    input  acc_kind_e      kind,
    input  logic [SW-1:0]  size,
    input  logic [AW-1:0]  disp,
    output logic [AW-1:0]  vaddr,
    output cause_e         cause
);
    logic          need_ok;
    logic [AW-1:0] nbytes;

    assign vaddr  = cap.base + cap.off + disp;
    assign nbytes = {{(AW-SW){1'b0}}, size};

    always_comb begin
        unique case (kind)
            AK_LOAD:  need_ok = cap.perm[PB_LOAD];
            AK_STORE: need_ok = cap.perm[PB_STORE];
            AK_FETCH: need_ok = cap.perm[PB_EXEC];
            default:  need_ok = 1'b0;
        endcase
    end

    always_comb begin
        if (!cap.tag)
            cause = CZ_TAG;
        else if (cap.sealed)
            cause = CZ_SEAL;
        else if (kind == AK_RSVD)
            cause = CZ_ILLEGAL;
        else if (!need_ok)
            cause = CZ_PERM;
        else if (!region_inside(cap.base, cap.len, vaddr, nbytes))
            cause = CZ_BOUNDS;
        else
            cause = CZ_NONE;
    end
endmodule

// File: rtl/cap_modify.sv
module cap_modify
    import cap_guard_pkg::*;
(
    input  cap_t           cap,
    input  logic [2:0]     op,
    input  logic [AW-1:0]  arg,
    input  logic [AW-1:0]  arg2,
    output cap_t           res,
    output cause_e         cause
);
    cap_t   trial;
    cause_e why;

    always_comb begin
        trial = cap;
        why   = CZ_NONE;
        if (!cap.tag) begin
            why = CZ_TAG;
        end else if (op == MO_UNSEAL) begin
            if (!cap.sealed)
                why = CZ_SEAL;
            else if (cap.otype != arg[OW-1:0])
                why = CZ_OTYPE;
            else begin
                trial.sealed = 1'b0;
                trial.otype  = '0;
            end
        end else if (cap.sealed) begin
            why = CZ_SEAL;
        end else begin
            case (op)
                MO_SETB: begin
                    if (region_inside(cap.base, cap.len, arg, arg2)) begin
                        trial.base = arg;
                        trial.len  = arg2;
                        trial.off  = '0;
                    end else begin
                        why = CZ_BOUNDS;
                    end
                end
                MO_ANDP: trial.perm = cap.perm & arg[PW-1:0];
                MO_INCO: trial.off  = cap.off + arg;
                MO_SEAL: begin
                    trial.sealed = 1'b1;
                    trial.otype  = arg[OW-1:0];
                end
                default: why = CZ_ILLEGAL;
            endcase
        end
    end

    // rights never change on a refused operation
    assign res   = (why == CZ_NONE) ? trial : cap;
    assign cause = why;
endmodule

// File: rtl/cap_guard.sv
module cap_guard
    import cap_guard_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic           req_is_mod,
    input  logic           req_cap_tag,
    input  logic [AW-1:0]  req_cap_base,
    input  logic [AW-1:0]  req_cap_len,
    input  logic [AW-1:0]  req_cap_off,
    input  logic [PW-1:0]  req_cap_perm,
    input  logic           req_cap_sealed,
    input  logic [OW-1:0]  req_cap_otype,
    input  logic [1:0]     req_acc_kind,
    input  logic [SW-1:0]  req_acc_size,
    input  logic [AW-1:0]  req_acc_disp,
    input  logic [2:0]     req_mod_op,
    input  logic [AW-1:0]  req_mod_arg,
    input  logic [AW-1:0]  req_mod_arg2,
    output logic           rsp_valid,
    input  logic           rsp_ready,
    output logic           rsp_fault,
    output logic [2:0]     rsp_cause,
    output logic [AW-1:0]  rsp_vaddr,
    output logic           rsp_cap_tag,
    output logic [AW-1:0]  rsp_cap_base,
    output logic [AW-1:0]  rsp_cap_len,
    output logic [AW-1:0]  rsp_cap_off,
    output logic [PW-1:0]  rsp_cap_perm,
    output logic           rsp_cap_sealed,
    output logic [OW-1:0]  rsp_cap_otype
);
    cap_t          in_cap, mod_cap, q_cap;
    cause_e        acc_cause, mod_cause, q_cause;
    logic [AW-1:0] acc_vaddr, q_vaddr;
    logic          q_valid, take;

    assign in_cap = '{tag: req_cap_tag, base: req_cap_base, len: req_cap_len,
                      off: req_cap_off, perm: req_cap_perm,
                      sealed: req_cap_sealed, otype: req_cap_otype};

    cap_access_chk u_acc (
        .cap   (in_cap),
        .kind  (acc_kind_e'(req_acc_kind)),
        .size  (req_acc_size),
        .disp  (req_acc_disp),
        .vaddr (acc_vaddr),
        .cause (acc_cause)
    );

    cap_modify u_mod (
        .cap   (in_cap),
        .op    (req_mod_op),
        .arg   (req_mod_arg),
        .arg2  (req_mod_arg2),
        .res   (mod_cap),
        .cause (mod_cause)
    );

    assign req_ready = !q_valid || rsp_ready;
    assign take      = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q_cap   <= '0;
            q_cause <= CZ_NONE;
            q_vaddr <= '0;
        end else if (take) begin
            q_valid <= 1'b1;
            q_cap   <= req_is_mod ? mod_cap : in_cap;
            q_cause <= req_is_mod ? mod_cause : acc_cause;
            q_vaddr <= req_is_mod ? '0 : acc_vaddr;
        end else if (rsp_ready) begin
            q_valid <= 1'b0;
        end
    end

    assign rsp_valid      = q_valid;
    assign rsp_fault      = (q_cause != CZ_NONE);
    assign rsp_cause      = q_cause;
    assign rsp_vaddr      = q_vaddr;
    assign rsp_cap_tag    = q_cap.tag;
    assign rsp_cap_base   = q_cap.base;
    assign rsp_cap_len    = q_cap.len;
    assign rsp_cap_off    = q_cap.off;
    assign rsp_cap_perm   = q_cap.perm;
    assign rsp_cap_sealed = q_cap.sealed;
    assign rsp_cap_otype  = q_cap.otype;
endmodule

// File: rtl/cap_guard_chk.sv
module cap_guard_chk
    import cap_guard_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           req_valid,
    input logic           req_ready,
    input logic           req_is_mod,
    input logic           req_cap_sealed,
    input logic [PW-1:0]  req_cap_perm,
    input logic [2:0]     req_mod_op,
    input logic           rsp_valid,
    input logic           rsp_ready,
    input logic           rsp_fault,
    input logic [2:0]     rsp_cause,
    input logic [AW-1:0]  rsp_vaddr,
    input logic           rsp_cap_tag,
    input logic [PW-1:0]  rsp_cap_perm
);
    logic just_taken;
    always_ff @(posedge clk) begin
        if (rst) just_taken <= 1'b0;
        else     just_taken <= req_valid && req_ready;
    end

    // R12: stalled result is held
    a_r12_hold: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_cause) && $stable(rsp_vaddr) && $stable(rsp_cap_perm)));

    // R12: no intake while the output is stalled
    a_r12_block: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |-> !req_ready);

    // R12: an accepted request yields a result next cycle
    a_r12_latency: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> rsp_valid);

    // R2: a successful result always carries a set tag
    a_r2_tag_kept: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_fault) |-> rsp_cap_tag);

    // R8: a manipulation never adds a permission bit
    a_r8_no_grow: assert property (@(posedge clk) disable iff (rst)
        (just_taken && $past(req_is_mod)) |-> ((rsp_cap_perm & ~$past(req_cap_perm)) == '0));

    // R3: sealed input to a non-unseal request faults
    a_r3_sealed_blocked: assert property (@(posedge clk) disable iff (rst)
        (just_taken && $past(req_cap_sealed) && !($past(req_is_mod) && $past(req_mod_op) == MO_UNSEAL))
        |-> (rsp_cause != 3'd0));
endmodule

bind cap_guard cap_guard_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_is_mod     (req_is_mod),
    .req_cap_sealed (req_cap_sealed),
    .req_cap_perm   (req_cap_perm),
    .req_mod_op     (req_mod_op),
    .rsp_valid      (rsp_valid),
    .rsp_ready      (rsp_ready),
    .rsp_fault      (rsp_fault),
    .rsp_cause      (rsp_cause),
    .rsp_vaddr      (rsp_vaddr),
    .rsp_cap_tag    (rsp_cap_tag),
    .rsp_cap_perm   (rsp_cap_perm)
);

// File: tb/cap_guard_tb.sv
`timescale 1ns/1ps
module cap_guard_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_ready, req_is_mod = 1'b0;
    logic        req_cap_tag = 1'b0, req_cap_sealed = 1'b0;
    logic [63:0] req_cap_base = '0, req_cap_len = '0, req_cap_off = '0;
    logic [30:0] req_cap_perm = '0;
    logic [23:0] req_cap_otype = '0;
    logic [1:0]  req_acc_kind = '0;
    logic [3:0]  req_acc_size = '0;
    logic [63:0] req_acc_disp = '0, req_mod_arg = '0, req_mod_arg2 = '0;
    logic [2:0]  req_mod_op = '0;
    logic        rsp_valid, rsp_ready = 1'b1, rsp_fault, rsp_cap_tag, rsp_cap_sealed;
    logic [2:0]  rsp_cause;
    logic [63:0] rsp_vaddr, rsp_cap_base, rsp_cap_len, rsp_cap_off;
    logic [30:0] rsp_cap_perm;
    logic [23:0] rsp_cap_otype;

    always #2.5 clk = ~clk;

    cap_guard u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_is_mod(req_is_mod), .req_cap_tag(req_cap_tag), .req_cap_base(req_cap_base),
        .req_cap_len(req_cap_len), .req_cap_off(req_cap_off), .req_cap_perm(req_cap_perm),
        .req_cap_sealed(req_cap_sealed), .req_cap_otype(req_cap_otype),
        .req_acc_kind(req_acc_kind), .req_acc_size(req_acc_size), .req_acc_disp(req_acc_disp),
        .req_mod_op(req_mod_op), .req_mod_arg(req_mod_arg), .req_mod_arg2(req_mod_arg2),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
        .rsp_cause(rsp_cause), .rsp_vaddr(rsp_vaddr), .rsp_cap_tag(rsp_cap_tag),
        .rsp_cap_base(rsp_cap_base), .rsp_cap_len(rsp_cap_len), .rsp_cap_off(rsp_cap_off),
        .rsp_cap_perm(rsp_cap_perm), .rsp_cap_sealed(rsp_cap_sealed), .rsp_cap_otype(rsp_cap_otype)
    );

    typedef struct {
        string       tag_name;
        logic [2:0]  cause;
        logic [63:0] vaddr, base, len, off;
        logic        ctag, sealed;
        logic [30:0] perm;
        logic [23:0] otype;
    } exp_t;

    exp_t   expq[$];
    int     n_checks = 0, n_errors = 0;
    string  cur_req = "R1";
    logic   prev_stall = 1'b0;
    logic [2:0]  s_cause;
    logic [63:0] s_vaddr, s_off;
    logic [30:0] s_perm;

    task automatic check(input string req, input string what, input logic [127:0] act, input logic [127:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // behavioural reference built from the requirement text
    function automatic exp_t predict();
        exp_t e;
        logic [64:0] top, lo, hi;
        logic [63:0] va;
        bit perm_ok;
        e.tag_name = cur_req;
        e.ctag = req_cap_tag; e.base = req_cap_base; e.len = req_cap_len; e.off = req_cap_off;
        e.perm = req_cap_perm; e.sealed = req_cap_sealed; e.otype = req_cap_otype;
        e.cause = 3'd0; e.vaddr = 64'd0;
        top = 65'(req_cap_base) + 65'(req_cap_len);
        if (!req_is_mod) begin
            va = req_cap_base + req_cap_off + req_acc_disp;
            e.vaddr = va;
            perm_ok = (req_acc_kind < 2'd3) && req_cap_perm[req_acc_kind];
            lo = 65'(va); hi = 65'(va) + 65'(req_acc_size);
            if (!req_cap_tag) e.cause = 3'd1;
            else if (req_cap_sealed) e.cause = 3'd2;
            else if (req_acc_kind == 2'd3) e.cause = 3'd6;
            else if (!perm_ok) e.cause = 3'd3;
            else if (lo < 65'(req_cap_base) || hi > top) e.cause = 3'd4;
        end else begin
            if (!req_cap_tag) e.cause = 3'd1;
            else if (req_mod_op == 3'd4) begin
                if (!req_cap_sealed) e.cause = 3'd2;
                else if (req_cap_otype != req_mod_arg[23:0]) e.cause = 3'd5;
                else begin e.sealed = 1'b0; e.otype = 24'd0; end
            end else if (req_cap_sealed) e.cause = 3'd2;
            else if (req_mod_op == 3'd0) begin
                lo = 65'(req_mod_arg); hi = 65'(req_mod_arg) + 65'(req_mod_arg2);
                if (lo < 65'(req_cap_base) || hi > top) e.cause = 3'd4;
                else begin e.base = req_mod_arg; e.len = req_mod_arg2; e.off = 64'd0; end
            end else if (req_mod_op == 3'd1) e.perm = req_cap_perm & req_mod_arg[30:0];
            else if (req_mod_op == 3'd2) e.off = req_cap_off + req_mod_arg;
            else if (req_mod_op == 3'd3) begin e.sealed = 1'b1; e.otype = req_mod_arg[23:0]; end
            else e.cause = 3'd6;
        end
        return e;
    endfunction

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            check("R12", "req_ready", 128'(req_ready), 128'(!rsp_valid || rsp_ready));
            if (prev_stall) begin
                check("R12", "held cause", 128'(rsp_cause), 128'(s_cause));
                check("R12", "held vaddr", 128'(rsp_vaddr), 128'(s_vaddr));
                check("R12", "held perm/off", {rsp_cap_perm, rsp_cap_off}, {s_perm, s_off});
            end
            prev_stall = rsp_valid && !rsp_ready;
            s_cause = rsp_cause; s_vaddr = rsp_vaddr; s_perm = rsp_cap_perm; s_off = rsp_cap_off;
            if (rsp_valid && rsp_ready) begin
                if (expq.size() == 0) check("R12", "unexpected result", 128'(1), 128'(0));
                else begin
                    exp_t e;
                    e = expq.pop_front();
                    check(e.tag_name, "cause", 128'(rsp_cause), 128'(e.cause));
                    check("R6", "fault flag", 128'(rsp_fault), 128'(e.cause != 3'd0));
                    check(e.tag_name, "vaddr", 128'(rsp_vaddr), 128'(e.vaddr));
                    check(e.tag_name, "base/len", {rsp_cap_base, rsp_cap_len}, {e.base, e.len});
                    check(e.tag_name, "off", 128'(rsp_cap_off), 128'(e.off));
                    check(e.tag_name, "perm/seal/otype/tag",
                          128'({rsp_cap_perm, rsp_cap_sealed, rsp_cap_otype, rsp_cap_tag}),
                          128'({e.perm, e.sealed, e.otype, e.ctag}));
                end
            end
            if (req_valid && req_ready) expq.push_back(predict());
        end
    end

    task automatic set_cap(input logic t, input logic [63:0] b, input logic [63:0] l,
                           input logic [63:0] o, input logic [30:0] p, input logic s, input logic [23:0] ot);
        req_cap_tag = t; req_cap_base = b; req_cap_len = l; req_cap_off = o;
        req_cap_perm = p; req_cap_sealed = s; req_cap_otype = ot;
    endtask

    task automatic fire();
        bit ok;
        req_valid = 1'b1;
        do begin
            @(negedge clk); ok = req_ready;
            @(posedge clk); #1;
        end while (!ok);
        req_valid = 1'b0;
    endtask

    task automatic acc(input string r, input logic [1:0] k, input logic [3:0] sz, input logic [63:0] d);
        cur_req = r; req_is_mod = 1'b0; req_acc_kind = k; req_acc_size = sz; req_acc_disp = d;
        fire();
    endtask

    task automatic mod(input string r, input logic [2:0] op, input logic [63:0] a, input logic [63:0] a2);
        cur_req = r; req_is_mod = 1'b1; req_mod_op = op; req_mod_arg = a; req_mod_arg2 = a2;
        fire();
    endtask

    initial begin
        #(200000 * 5);
        n_errors++; n_checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R13: reset state
        check("R13", "rsp_valid in reset", 128'(rsp_valid), 128'(0));
        check("R13", "req_ready in reset", 128'(req_ready), 128'(1));
        rst = 1'b0;
        @(negedge clk);
        check("R13", "rsp_valid after reset", 128'(rsp_valid), 128'(0));
        @(posedge clk); #1;

        // R1: plain load
        set_cap(1, 64'h1000, 64'h100, 64'h10, 31'h7, 0, 0);
        acc("R1", 2'd0, 4'd4, 64'h4);
        // R4: permission gating
        set_cap(1, 64'h1000, 64'h100, 64'h10, 31'h1, 0, 0);
        acc("R4", 2'd1, 4'd4, 64'h0);
        set_cap(1, 64'h1000, 64'h100, 64'h10, 31'h3, 0, 0);
        acc("R4", 2'd2, 4'd4, 64'h0);
        set_cap(1, 64'h1000, 64'h100, 64'h10, 31'h4, 0, 0);
        acc("R4", 2'd2, 4'd4, 64'h0);
        acc("R4", 2'd3, 4'd4, 64'h0);
        // R2 / R6: untagged and sealed, tag wins
        set_cap(0, 64'h1000, 64'h100, 64'h10, 31'h0, 1, 24'h5);
        acc("R2", 2'd1, 4'd8, 64'h9000);
        mod("R2", 3'd4, 64'h5, 0);
        // R3: sealed load and sealed manipulation
        set_cap(1, 64'h1000, 64'h100, 64'h10, 31'h7, 1, 24'h5);
        acc("R3", 2'd0, 4'd1, 64'h0);
        mod("R3", 3'd1, 64'h0, 0);
        // R5: exact top ok, one past fails
        set_cap(1, 64'h1000, 64'h100, 64'h0, 31'h7, 0, 0);
        acc("R5", 2'd0, 4'd8, 64'hF8);
        acc("R5", 2'd0, 4'd8, 64'hF9);
        // R5: region ending at 2^64, and wrapped address below base
        set_cap(1, 64'hFFFF_FFFF_FFFF_FF00, 64'h100, 64'hF8, 31'h7, 0, 0);
        acc("R5", 2'd0, 4'd8, 64'h0);
        acc("R5", 2'd0, 4'd8, 64'h1);
        acc("R5", 2'd0, 4'd4, 64'h10);
        // R6: permission and bounds together, permission reported
        set_cap(1, 64'h1000, 64'h100, 64'h0, 31'h1, 0, 0);
        acc("R6", 2'd1, 4'd8, 64'h500);
        // R7: subset and superset
        set_cap(1, 64'h1000, 64'h100, 64'h40, 31'h7, 0, 0);
        mod("R7", 3'd0, 64'h1020, 64'h20);
        mod("R7", 3'd0, 64'h1020, 64'hE1);
        mod("R7", 3'd0, 64'h0FFF, 64'h2);
        // R8: mask
        set_cap(1, 64'h1000, 64'h100, 64'h40, 31'h7, 0, 0);
        mod("R8", 3'd1, 64'hFFFF_FFFF_FFFF_FFFA, 0);
        // R9: increment beyond bounds
        mod("R9", 3'd2, 64'h1_0000, 0);
        // R10: seal
        mod("R10", 3'd3, 64'hAB_CDEF, 0);
        // R11: unseal match, mismatch, unsealed, illegal ops
        set_cap(1, 64'h1000, 64'h100, 64'h40, 31'h7, 1, 24'hABCDEF);
        mod("R11", 3'd4, 64'hABCDEF, 0);
        mod("R11", 3'd4, 64'hABCDEE, 0);
        set_cap(1, 64'h1000, 64'h100, 64'h40, 31'h7, 0, 24'h0);
        mod("R11", 3'd4, 64'h0, 0);
        mod("R11", 3'd5, 64'h0, 0);
        mod("R11", 3'd7, 64'h0, 0);

        // R12: stall the output while requests queue up
        rsp_ready = 1'b0;
        fork
            begin
                set_cap(1, 64'h2000, 64'h80, 64'h0, 31'h7, 0, 0);
                acc("R12", 2'd0, 4'd2, 64'h7E);
                acc("R12", 2'd1, 4'd2, 64'h7F);
                mod("R12", 3'd2, 64'h3, 0);
            end
            begin
                repeat (4) @(posedge clk);
                #1 rsp_ready = 1'b1;
                repeat (2) @(posedge clk);
                #1 rsp_ready = 1'b0;
                repeat (3) @(posedge clk);
                #1 rsp_ready = 1'b1;
            end
        join
        repeat (6) @(posedge clk);
        #1;
        check("R12", "all results drained", 128'(expq.size()), 128'(0));
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule